// File: doc/BRIEF.md
# TDM Serial Sample Transmitter

This block places converter sample words on a single time-division multiplexed data line. Both the bit clock and the frame sync come from outside the block. Their sources are not part of this design. The block samples both of them in its own system clock domain and finds each falling edge of the bit clock. A frame begins on the first falling edge at which frame sync is seen high after being seen low. On that edge the block copies every channel word and the frame-size selection into shadow registers. It then drives one bit per bit clock, most significant bit first, with each slot 32 bit clocks long.

Two frame sizes are available. In the 8-slot frame (256 bit clocks), the first four slots carry channel words and the last four slots pad the frame as unused time. In the 16-slot frame (512 bit clocks), eight channel words fill the first eight slots and the remaining eight slots stay unused. The 16-slot frame needs a bit clock twice as fast. It is therefore meant only for the lower sample-rate group: 32, 44.1 and 48 kHz. Whenever the line carries no active channel bit, it is held at 0.

Top module: `tdm_adc_tx`

## Requirements
- R1: After reset, dout_o is 0, and it stays 0 while the bit clock toggles with no frame start.
- R2: In an active slot k, dout_o carries channel word k over 32 bit clocks, bit 31 first and bit 0 last. The first bit appears after the falling edge that starts the frame. Word k is ch_data_i[32k+31:32k].
- R3: With mode16_i = 0 captured, a frame is 256 bit clocks long. Words 0 to 3 fill slots 0 to 3, and slots 4 to 7 are driven 0 for all their bits, whatever words 4 to 7 hold.
- R4: With mode16_i = 1 captured, a frame is 512 bit clocks long. Words 0 to 7 fill slots 0 to 7, and slots 8 to 15 are driven 0.
- R5: A frame starts at a falling edge of bclk_i where fsync_i is sampled 1 and was sampled 0 at the previous falling edge. Holding fsync_i high over further falling edges does not restart the frame.
- R6: Channel words and mode16_i are captured only at frame start. Changing them during a frame has no effect on the bits of that frame.
- R7: dout_o changes only as a result of a bclk_i falling edge, within SYNC_STAGES+1 system clocks of it. It holds steady through the following high phase and the rising edge.
- R8: After the last bit of a frame, if no new start occurs, dout_o stays 0 until the next start.
- R9: A start detected partway through a frame abandons that frame. Slot 0 of the newly captured words begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | External TDM bit clock |
| fsync_i | input | 1 | External frame sync, sampled on bit clock falling edges |
| mode16_i | input | 1 | 0: 8-slot frame, 1: 16-slot frame (captured at frame start) |
| ch_data_i | input | MAX_CH*SLOT_W | Channel words, word k in bits [SLOT_W*k +: SLOT_W] |
| dout_o | output | 1 | TDM serial data out |

## Verification
The main function is tried with several kinds of frames: an 8-slot frame whose padding words are all ones, a back-to-back 8-slot frame with a long frame sync and with its inputs changed in mid-frame, a 16-slot frame, and a frame cut short by an early sync. The all-ones padding words show whether the padding slots are truly forced low. Asymmetric word patterns (a single bit set at each end, alternating nibbles, counting bytes) expose bit order and slot order errors. The changes in mid-frame separate a correct shadow capture from a live input path. The long sync and the early sync tell edge detection from level detection, and show that a restart goes back to slot 0. Every line sample is compared with a behavioural model, both just after the rising edge and just before the next falling edge.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  typedef enum logic {
    FRM_8SLOT  = 1'b0,
    FRM_16SLOT = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/tdm_tx_sync.sv
module tdm_tx_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/tdm_tx_seq.sv
module tdm_tx_seq
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int SLOTS  = 8,
  localparam int CNT_W = $clog2(2 * SLOTS * SLOT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             fs_i,
  input  frame_mode_e      mode_i,
  output logic             start_o,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output frame_mode_e      mode_o
);
  localparam logic [CNT_W-1:0] LAST_8  = CNT_W'(SLOTS * SLOT_W - 1);
  localparam logic [CNT_W-1:0] LAST_16 = CNT_W'(2 * SLOTS * SLOT_W - 1);

  logic             fs_prev_q;
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  frame_mode_e      mode_q;
  logic [CNT_W-1:0] last_w;

  assign start_o = fall_i & fs_i & ~fs_prev_q;
  assign last_w  = (mode_q == FRM_16SLOT) ? LAST_16 : LAST_8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_prev_q <= 1'b0;
      active_q  <= 1'b0;
      cnt_q     <= '0;
      mode_q    <= FRM_8SLOT;
    end else if (fall_i) begin
      fs_prev_q <= fs_i;
      if (start_o) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        mode_q   <= mode_i;
      end else if (active_q) begin
        if (cnt_q == last_w) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign mode_o   = mode_q;
endmodule

// File: rtl/tdm_tx_shadow.sv
module tdm_tx_shadow #(
  parameter int SLOT_W = 32,
  parameter int MAX_CH = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [MAX_CH*SLOT_W-1:0]      data_i,
  output logic [MAX_CH-1:0][SLOT_W-1:0] words_o
);
  for (genvar k = 0; k < MAX_CH; k++) begin : g_word
    logic [SLOT_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     word_q <= '0;
      else if (load_i) word_q <= data_i[k*SLOT_W +: SLOT_W];
    end
    assign words_o[k] = word_q;
  end
endmodule

// File: rtl/tdm_tx_mux.sv
module tdm_tx_mux
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int ACT_CH = 4,
  parameter int MAX_CH = 8,
  parameter int CNT_W  = 9
) (
  input  logic                          active_i,
  input  frame_mode_e                   mode_i,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [MAX_CH-1:0][SLOT_W-1:0] words_i,
  output logic                          bit_o
);
  localparam int BIT_W  = $clog2(SLOT_W);
  localparam int SLOT_IW = CNT_W - BIT_W;

  logic [SLOT_IW-1:0] slot_w;
  logic [BIT_W-1:0]   bidx_w;
  logic [SLOT_IW-1:0] n_act_w;
  logic [MAX_CH-1:0]  pick_w;

  assign slot_w  = cnt_i[CNT_W-1:BIT_W];
  assign bidx_w  = cnt_i[BIT_W-1:0];
  assign n_act_w = (mode_i == FRM_16SLOT) ? SLOT_IW'(MAX_CH) : SLOT_IW'(ACT_CH);

  // MSB first: bit counter 0 selects the top bit of the word
  for (genvar k = 0; k < MAX_CH; k++) begin : g_pick
    assign pick_w[k] = (slot_w == SLOT_IW'(k)) & words_i[k][BIT_W'(SLOT_W-1) - bidx_w];
  end

  assign bit_o = active_i & (slot_w < n_act_w) & (|pick_w);
endmodule

// File: rtl/tdm_adc_tx.sv
module tdm_adc_tx
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W      = 32,
  parameter int ACT_CH      = 4,
  parameter int SLOTS       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int MAX_CH     = 2 * ACT_CH,
  localparam int CNT_W      = $clog2(2 * SLOTS * SLOT_W)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bclk_i,
  input  logic                     fsync_i,
  input  logic                     mode16_i,
  input  logic [MAX_CH*SLOT_W-1:0] ch_data_i,
  output logic                     dout_o
);
  logic [1:0]                    sync_w;
  logic                          bclk_prev_q;
  logic                          fall_w;
  logic                          start_w;
  logic                          active_w;
  logic [CNT_W-1:0]              cnt_w;
  frame_mode_e                   mode_q;
  frame_mode_e                   mode_in_w;
  logic [MAX_CH-1:0][SLOT_W-1:0] words_w;

  tdm_tx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({fsync_i, bclk_i}),
    .sync_o (sync_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_prev_q <= 1'b0;
    else         bclk_prev_q <= sync_w[0];
  end

  assign fall_w    = bclk_prev_q & ~sync_w[0];
  assign mode_in_w = mode16_i ? FRM_16SLOT : FRM_8SLOT;

  tdm_tx_seq #(.SLOT_W(SLOT_W), .SLOTS(SLOTS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (fall_w),
    .fs_i    (sync_w[1]),
    .mode_i  (mode_in_w),
    .start_o (start_w),
    .active_o(active_w),
    .cnt_o   (cnt_w),
    .mode_o  (mode_q)
  );

  tdm_tx_shadow #(.SLOT_W(SLOT_W), .MAX_CH(MAX_CH)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_w),
    .data_i (ch_data_i),
    .words_o(words_w)
  );

  tdm_tx_mux #(
    .SLOT_W(SLOT_W), .ACT_CH(ACT_CH), .MAX_CH(MAX_CH), .CNT_W(CNT_W)
  ) u_mux (
    .active_i(active_w),
    .mode_i  (mode_q),
    .cnt_i   (cnt_w),
    .words_i (words_w),
    .bit_o   (dout_o)
  );
endmodule

// File: rtl/tdm_adc_tx_chk.sv
module tdm_adc_tx_chk
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int ACT_CH = 4,
  parameter int SLOTS  = 8,
  parameter int CNT_W  = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fall_i,
  input logic             start_i,
  input logic             active_i,
  input logic [CNT_W-1:0] cnt_i,
  input frame_mode_e      mode_i,
  input logic             dout_i
);
  localparam int BIT_W  = $clog2(SLOT_W);
  localparam int SLOT_IW = CNT_W - BIT_W;
  localparam logic [CNT_W-1:0] LAST_8  = CNT_W'(SLOTS * SLOT_W - 1);
  localparam logic [CNT_W-1:0] LAST_16 = CNT_W'(2 * SLOTS * SLOT_W - 1);

  logic [SLOT_IW-1:0] slot_w;
  assign slot_w = cnt_i[CNT_W-1:BIT_W];

  a_r7_change_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fall_i) |-> $stable(dout_i));

  a_r8_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !dout_i);

  a_r3_pad_low_8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && mode_i == FRM_8SLOT && slot_w >= SLOT_IW'(ACT_CH)) |-> !dout_i);

  a_r4_pad_low_16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && mode_i == FRM_16SLOT && slot_w >= SLOT_IW'(2 * ACT_CH)) |-> !dout_i);

  a_r5_start_slot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_i && cnt_i == '0));

  a_r2_bit_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !start_i && active_i && cnt_i != LAST_8 && cnt_i != LAST_16)
      |=> (active_i && cnt_i == $past(cnt_i) + 1'b1));

  a_r3_len_8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !start_i && active_i && mode_i == FRM_8SLOT && cnt_i == LAST_8) |=> !active_i);
endmodule

bind tdm_adc_tx tdm_adc_tx_chk #(
  .SLOT_W(SLOT_W), .ACT_CH(ACT_CH), .SLOTS(SLOTS), .CNT_W(CNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .fall_i  (fall_w),
  .start_i (start_w),
  .active_i(active_w),
  .cnt_i   (cnt_w),
  .mode_i  (mode_q),
  .dout_i  (dout_o)
);

// File: tb/tb_tdm_adc_tx.sv
module tb_tdm_adc_tx;
  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            bclk = 1'b1;
  logic            fsync = 1'b0;
  logic            mode16 = 1'b0;
  logic [7:0][31:0] data = '0;
  logic            dout;

  int errors = 0;
  int checks = 0;
  string scen = "R1";

  // behavioural model state
  int               pos = -1;
  logic             fs_prev_m = 1'b0;
  logic [7:0][31:0] snap = '0;
  logic             m16 = 1'b0;

  always #10 clk = ~clk;

  tdm_adc_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_i(bclk), .fsync_i(fsync),
    .mode16_i(mode16), .ch_data_i(data), .dout_o(dout)
  );

  function automatic logic exp_bit();
    int slot, nact;
    if (pos < 0) return 1'b0;
    slot = pos / 32;
    nact = m16 ? 8 : 4;
    if (slot >= nact) return 1'b0;
    return snap[slot][31 - (pos % 32)];
  endfunction

  function automatic string exp_tag();
    if (pos < 0) return "R8";
    if (pos / 32 >= (m16 ? 8 : 4)) return m16 ? "R4" : "R3";
    return "R2";
  endfunction

  task automatic check(input string tag);
    logic e;
    e = exp_bit();
    checks++;
    if (dout !== e) begin
      errors++;
      $display("FAIL %s (%s) pos=%0d: dout=%0b expected %0b", tag, scen, pos, dout, e);
    end
  endtask

  task automatic tick(input logic fs_next);
    @(negedge clk);
    bclk = 1'b0;
    if (fsync && !fs_prev_m) begin
      pos = 0; snap = data; m16 = mode16;
    end else if (pos >= 0) begin
      pos++;
      if (pos == (m16 ? 512 : 256)) pos = -1;
    end
    fs_prev_m = fsync;
    repeat (6) @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
    check("R7");
    fsync = fs_next;
    repeat (3) @(negedge clk);
    check(exp_tag());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (dout !== 1'b0) begin
      errors++;
      $display("FAIL R1: dout=%0b expected 0", dout);
    end
    for (int i = 0; i < 16; i++) tick(1'b0);

    // R3/R2: 8-slot frame, padding words all ones, one-bit sync
    scen = "R3";
    data[0] = 32'h8000_0001; data[1] = 32'hA5A5_5A5A;
    data[2] = 32'h0123_4567; data[3] = 32'hFEDC_BA98;
    for (int k = 4; k < 8; k++) data[k] = 32'hFFFF_FFFF;
    mode16 = 1'b0;
    tick(1'b1);
    for (int i = 0; i < 256; i++) tick(i == 255);

    // R5/R6: back-to-back frame, wide sync, inputs changed mid-frame
    scen = "R5";
    data[0] = 32'h0F0F_F0F0; data[1] = 32'h1357_9BDF;
    data[2] = 32'h7FFF_FFFE; data[3] = 32'h0000_8000;
    for (int i = 0; i < 256; i++) begin
      if (i == 100) begin
        scen = "R6";
        data = {8{32'h5555_AAAA}};
        mode16 = 1'b1;
      end
      tick(i < 31);
    end

    // R8: no new sync, line must stay low
    scen = "R8";
    for (int i = 0; i < 20; i++) tick(1'b0);

    // R4: 16-slot frame
    scen = "R4";
    mode16 = 1'b1;
    for (int k = 0; k < 8; k++) data[k] = 32'h0101_0101 * (k + 1) ^ 32'h8000_0000;
    tick(1'b1);
    for (int i = 0; i < 512; i++) tick(1'b0);
    for (int i = 0; i < 4; i++) tick(1'b0);

    // R9: restart partway through an 8-slot frame
    scen = "R9";
    mode16 = 1'b0;
    data[0] = 32'hC000_0003; data[1] = 32'h3C3C_3C3C;
    data[2] = 32'hDEAD_BEEF; data[3] = 32'h0000_0001;
    tick(1'b1);
    for (int i = 0; i < 100; i++) begin
      if (i == 50) begin
        data[0] = 32'h1234_5678; data[1] = 32'h9ABC_DEF0;
        data[2] = 32'h8888_1111; data[3] = 32'hF00F_0FF0;
      end
      tick(i == 99);
    end
    for (int i = 0; i < 256; i++) tick(1'b0);
    for (int i = 0; i < 4; i++) tick(1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule